// File: doc/BRIEF.md
# Converter Result Read-Order Register

This block is the bus-facing storage for the result of a 10-bit successive-approximation converter. It keeps the last completed result and shows it through two byte-wide read addresses, a low register and a high register. A new-result strobe with a 10-bit value updates the stored result. A conversion-start pulse marks the start of a new conversion. Reads taken between the start and the new result still see the previous result.

The high register also holds a writable mode-select bit, which chooses between 10-bit and 8-bit operation. In 10-bit mode, software can fetch the full value by reading the high register first and then the low register. It can instead read only the low register, which then gives the eight most significant bits. A flag inside the block records whether the high register has been read since the last conversion start, and that flag steers the low register. In 8-bit mode, the low register always carries the 8-bit result in result bits 7..0.

Read data is combinational from the address while a one-cycle read strobe is high. The read-order flag changes at the clock edge that ends the strobe.

Top module: `adc_result_port`

## Requirements
- R1: After reset, the stored result is 0, the mode bit is 0 (10-bit mode) and the read-order flag is clear. Reads of the low and high registers return 0x00, and `mode_8bit` is 0.
- R2: The stored result takes `res_data` at the clock edge where `res_valid` is 1, and at no other time. A conversion-start pulse alone leaves it unchanged, so reads after a start and before the new result return the previous result.
- R3: A read of the high register (address 0x38) returns the mode bit in bit 7, zeros in bits 6..2, and result bits 9..8 in bits 1..0.
- R4: In 10-bit mode with the flag clear, a read of the low register (address 0x35) returns result bits 9..2.
- R5: A read of the high register sets the flag at the edge that ends the read. While the flag is set in 10-bit mode, every read of the low register returns result bits 7..0.
- R6: A conversion-start pulse clears the flag. If the start and a high-register read fall in the same cycle, the start wins and the flag is clear afterwards.
- R7: In 8-bit mode (mode bit 1), a read of the low register returns result bits 7..0 whatever the state of the flag.
- R8: A write to address 0x38 loads write-data bit 7 into the mode bit, which appears on `mode_8bit` from the next cycle. Other write-data bits are ignored, and writes to 0x35 or any other address change neither the mode nor the result.
- R9: `bus_rdata` is 0x00 when `bus_rd` is 0 or the address is neither 0x35 nor 0x38. A read of any other address does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | New-result strobe from the converter |
| res_data | input | 10 | Completed conversion value |
| conv_start | input | 1 | Conversion-start pulse |
| bus_addr | input | 8 | Byte address for read or write |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address during the read strobe |
| mode_8bit | output | 1 | Mode bit: 0 selects 10-bit mode, 1 selects 8-bit mode |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples `bus_rdata` at the falling edge within that strobe cycle. The stored result, the mode bit and the read-order flag each update at the rising edge that ends their strobe, so their effects are observed no earlier than the following cycle. The mode is checked on `mode_8bit`, and the result and flag are checked through a later low-register read. The bench drives inputs one time unit after the rising edge, which keeps every sample one register stage away from the edge that changes it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    localparam int RES_W_DEF  = 10;
    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 8;
    localparam int MODE_BIT_DEF = 7;

    typedef struct packed {
        logic [RES_W_DEF-1:0] result;
        logic                 mode8;
    } hold_state_t;

    typedef struct packed {
        logic lsb_side;
    } order_state_t;
endpackage

// File: rtl/adc_res_hold.sv
module adc_res_hold
    import adc_rd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [RES_W_DEF-1:0] load_data,
    input  logic                 mode_we,
    input  logic                 mode_wdata,
    output logic [RES_W_DEF-1:0] result,
    output logic                 mode8
);
    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.result = load_data;
        end
        if (mode_we) begin
            st_d.mode8 = mode_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
    assign mode8  = st_q.mode8;

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.result == $past(load_data)));
    assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.result));
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_we |=> $stable(st_q.mode8));
endmodule

// File: rtl/adc_rd_order.sv
module adc_rd_order
    import adc_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hi_rd,
    output logic lsb_side
);
    order_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.lsb_side = 1'b0;
        end else if (hi_rd) begin
            st_d.lsb_side = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lsb_side = st_q.lsb_side;

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !st_q.lsb_side);
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && !start) |=> st_q.lsb_side);
    assert_flag_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_rd && !start) |=> $stable(st_q.lsb_side));
endmodule

// File: rtl/adc_rd_mux.sv
module adc_rd_mux
    import adc_rd_pkg::*;
#(
    parameter int                    ADDR_W   = ADDR_W_DEF,
    parameter int                    DATA_W   = DATA_W_DEF,
    parameter int                    RES_W    = RES_W_DEF,
    parameter int                    MODE_BIT = MODE_BIT_DEF,
    parameter logic [ADDR_W-1:0]     LO_ADDR  = 8'h35,
    parameter logic [ADDR_W-1:0]     HI_ADDR  = 8'h38
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RES_W-1:0]  result,
    input  logic              mode8,
    input  logic              lsb_side,
    output logic [DATA_W-1:0] rdata
);
    localparam int TOP_W = RES_W - DATA_W;

    logic [DATA_W-1:0] lo_msb, lo_lsb, hi_word;

    always_comb begin
        lo_msb = result[RES_W-1 -: DATA_W];
        lo_lsb = result[DATA_W-1:0];
        hi_word = '0;
        for (int i = 0; i < TOP_W; i++) begin
            hi_word[i] = result[DATA_W+i];
        end
        hi_word[MODE_BIT] = mode8;
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == LO_ADDR) begin
                rdata = (mode8 || lsb_side) ? lo_lsb : lo_msb;
            end else if (addr == HI_ADDR) begin
                rdata = hi_word;
            end
        end
    end
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
    import adc_rd_pkg::*;
#(
    parameter int                ADDR_W   = ADDR_W_DEF,
    parameter int                DATA_W   = DATA_W_DEF,
    parameter int                MODE_BIT = MODE_BIT_DEF,
    parameter logic [ADDR_W-1:0] LO_ADDR  = 8'h35,
    parameter logic [ADDR_W-1:0] HI_ADDR  = 8'h38
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_valid,
    input  logic [RES_W_DEF-1:0] res_data,
    input  logic                 conv_start,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 mode_8bit
);
    localparam int RES_W = RES_W_DEF;
    localparam int TOP_W = RES_W - DATA_W;

    logic             hi_rd, mode_we, lsb_side, mode8;
    logic [RES_W-1:0] result;

    assign hi_rd   = bus_rd && (bus_addr == HI_ADDR);
    assign mode_we = bus_wr && (bus_addr == HI_ADDR);

    adc_res_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (res_valid),
        .load_data  (res_data),
        .mode_we    (mode_we),
        .mode_wdata (bus_wdata[MODE_BIT]),
        .result     (result),
        .mode8      (mode8)
    );

    adc_rd_order u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (conv_start),
        .hi_rd    (hi_rd),
        .lsb_side (lsb_side)
    );

    adc_rd_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RES_W    (RES_W),
        .MODE_BIT (MODE_BIT),
        .LO_ADDR  (LO_ADDR),
        .HI_ADDR  (HI_ADDR)
    ) u_mux (
        .rd       (bus_rd),
        .addr     (bus_addr),
        .result   (result),
        .mode8    (mode8),
        .lsb_side (lsb_side),
        .rdata    (bus_rdata)
    );

    assign mode_8bit = mode8;

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
    assert_hi_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |-> (bus_rdata[MODE_BIT-1:TOP_W] == '0));
    assert_hi_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_rd |-> (bus_rdata[MODE_BIT] == mode_8bit));
    assert_mode_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_8bit == $past(bus_wdata[MODE_BIT])));
    assert_lo_8bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == LO_ADDR && mode_8bit) |-> (bus_rdata == result[DATA_W-1:0]));
endmodule

// File: tb/adc_result_port_tb.sv
module adc_result_port_tb_top;
    localparam logic [7:0] LO = 8'h35;
    localparam logic [7:0] HI = 8'h38;

    // vector: {res[9:0], mode8, hi_first, exp_lo[7:0], exp_hi[7:0]}
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {10'h3FF, 1'b0, 1'b0, 8'hFF, 8'h03},
        {10'h2A5, 1'b0, 1'b0, 8'hA9, 8'h02},
        {10'h2A5, 1'b0, 1'b1, 8'hA5, 8'h02},
        {10'h15A, 1'b0, 1'b1, 8'h5A, 8'h01},
        {10'h15A, 1'b0, 1'b0, 8'h56, 8'h01},
        {10'h0C3, 1'b1, 1'b0, 8'hC3, 8'h80},
        {10'h0C3, 1'b1, 1'b1, 8'hC3, 8'h80},
        {10'h003, 1'b0, 1'b0, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_valid = 1'b0;
    logic [9:0] res_data = '0;
    logic       conv_start = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mode_8bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_result_port dut_i (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .conv_start(conv_start), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_8bit(mode_8bit)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // all tasks start and end one time unit after a rising edge
    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        chk(req, bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic do_load(input logic [9:0] v);
        res_valid = 1'b1; res_data = v;
        @(posedge clk); #1;
        res_valid = 1'b0;
    endtask

    task automatic do_start();
        conv_start = 1'b1;
        @(posedge clk); #1;
        conv_start = 1'b0;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk(req, bus_rdata, 8'h00);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk("R1 mode", {7'd0, mode_8bit}, 8'h00);
        do_read(LO, 8'h00, "R1 low");
        do_read(HI, 8'h00, "R1 high");

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            do_write(HI, {v[17], 7'h7F});
            chk("R8 mode port", {7'd0, mode_8bit}, {7'd0, v[17]});
            do_start();
            do_load(v[27:18]);
            if (v[16]) do_read(HI, v[7:0], "R3 high");
            do_read(LO, v[15:8], v[17] ? "R7 low 8bit" : (v[16] ? "R5 low lsb" : "R4 low msb"));
        end

        // R2: start alone keeps old value; reads in flight see previous result
        do_write(HI, 8'h00);
        do_load(10'h2A5);
        do_start();
        do_read(LO, 8'hA9, "R2 previous result after start");
        do_load(10'h15A);
        do_read(LO, 8'h56, "R2 new result");

        // R5: flag persists across repeated low reads
        do_read(HI, 8'h01, "R3 high 10bit");
        do_read(LO, 8'h5A, "R5 first low");
        do_read(LO, 8'h5A, "R5 second low");

        // R6: start clears flag
        do_start();
        do_read(LO, 8'h56, "R6 after start");
        // R6: simultaneous start and high read, start wins
        bus_rd = 1'b1; bus_addr = HI; conv_start = 1'b1;
        @(negedge clk);
        chk("R6 high during start", bus_rdata, 8'h01);
        @(posedge clk); #1;
        bus_rd = 1'b0; conv_start = 1'b0;
        do_read(LO, 8'h56, "R6 start wins");

        // R7: 8-bit mode ignores flag in both states
        do_write(HI, 8'h80);
        do_read(LO, 8'h5A, "R7 flag clear");
        do_read(HI, 8'h81, "R3 high 8bit");
        do_read(LO, 8'h5A, "R7 flag set");

        // R8: writes elsewhere ignored
        do_start();
        do_write(LO, 8'h00);
        chk("R8 low write keeps mode", {7'd0, mode_8bit}, 8'h01);
        do_write(HI, 8'h7F);
        chk("R8 bit7 clear", {7'd0, mode_8bit}, 8'h00);
        do_write(8'h36, 8'h80);
        chk("R8 other addr", {7'd0, mode_8bit}, 8'h00);
        do_read(LO, 8'h56, "R8 result unchanged by writes");

        // R9: idle and unmapped reads
        bus_addr = LO;
        idle_check("R9 no strobe");
        do_read(8'h36, 8'h00, "R9 unmapped");
        do_read(LO, 8'h56, "R9 unmapped read leaves flag clear");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule